// File: doc/BRIEF.md
# Integer ALU With Set-Conditional

This block is the integer execution datapath of a small load-store processor. It is purely combinational: an operation code selects one of addition, subtraction, bitwise AND/OR/XOR, three shift kinds, a load-high operation, or one of six relational "set" operations. Each set operation writes the value 1 or 0 into the result. The second operand is either a register value or a 16-bit immediate, chosen by a select flag. A separate unsigned flag picks the unsigned form of add, subtract and the comparisons.

The block owns the rule for widening the immediate. It sign-extends the immediate for signed add, signed subtract and signed comparisons. It zero-extends the immediate for logical operations, for shifts and for every unsigned form. Alongside the 32-bit result it drives an overflow flag, which reports two's-complement overflow of signed add and subtract only.

Top module: `int_alu_setcond`

## Requirements
- R1: Operation code 0 (add) gives A+B and code 1 (subtract) gives A-B, both modulo 2^32. With the immediate selected, B is the 16-bit immediate, sign-extended when the unsigned flag is 0 and zero-extended when it is 1.
- R2: The overflow flag is 1 only for codes 0 and 1 with the unsigned flag at 0, and only when the exact signed result lies outside the range -2^31 to 2^31-1. It is 0 for every other code and for all unsigned forms.
- R3: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of A and B. A selected immediate is zero-extended.
- R4: Codes 5, 6 and 7 shift A left logically, right logically and right arithmetically. The shift amount is the low 5 bits of B or of the zero-extended immediate, and higher bits of the amount have no effect.
- R5: Code 8 (load high) puts the 16-bit immediate in result bits 31:16 and clears bits 15:0. Operand A, operand B and the immediate-select flag play no part.
- R6: Codes 9 to 14 are the set operations EQ, NE, LT, GT, LE and GE, in that order, comparing A with B. With the unsigned flag at 0 they compare as signed two's-complement values. The result is exactly 1 when the condition holds and 0 otherwise.
- R7: With the unsigned flag at 1, codes 9 to 14 compare A and B as unsigned values. A selected immediate is zero-extended.
- R8: Code 15 is unassigned and gives a zero result with the overflow flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation selector (encoding in R1 to R8) |
| uns_sel | input | 1 | 1 selects unsigned add, subtract and compares |
| imm_sel | input | 1 | 1 takes the second operand from imm_val |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second register operand |
| imm_val | input | 16 | Immediate field |
| alu_result | output | 32 | Result of the operation |
| alu_ovf | output | 1 | Signed add or subtract overflow |

## Verification
The block holds no state, so any wrong internal decision shows up at the ports in the same evaluation in which the inputs change. A wrong widening of the immediate shows up as a wrong sum or a flipped comparison. The bench exercises this with immediates whose bit 15 is set. A broken shifter stage corrupts every shift amount that sets that stage's bit. The bench sweeps all codes, both flags and operand corner values, including the sign boundaries and amounts above 31, so these faults show up in the compare count straight away.

// File: rtl/alu_pkg.sv
// Package alu_pkg
// Shared operation encoding and widths for the set-conditional integer ALU.
// Assumes the data word is exactly twice the immediate width.
package alu_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned IMM_W = 16;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SLL = 4'd5,
        OP_SRL = 4'd6,
        OP_SRA = 4'd7,
        OP_LHI = 4'd8,
        OP_SEQ = 4'd9,
        OP_SNE = 4'd10,
        OP_SLT = 4'd11,
        OP_SGT = 4'd12,
        OP_SLE = 4'd13,
        OP_SGE = 4'd14,
        OP_NUL = 4'd15
    } alu_op_e;

    // True for operations whose immediate is widened with its sign bit
    function automatic logic op_is_signed_kind(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) ||
               ((op >= OP_SEQ) && (op <= OP_SGE));
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
// Module alu_operand_sel
// Builds the effective second operand: the register value, or the immediate
// widened by sign or zero extension according to operation and unsigned flag.
// Assumes W > IW.
module alu_operand_sel #(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 16
) (
    input  alu_pkg::alu_op_e op,
    input  logic             uns_sel,
    input  logic             imm_sel,
    input  logic [W-1:0]     reg_b,
    input  logic [IW-1:0]    imm,
    output logic [W-1:0]     b_eff
);
    localparam int unsigned PADW = W - IW;

    logic          use_sext;
    logic [W-1:0]  imm_wide;

    // Decide the extension policy and select the operand source
    always_comb begin
        use_sext = alu_pkg::op_is_signed_kind(op) && !uns_sel;
        imm_wide = use_sext ? {{PADW{imm[IW-1]}}, imm} : {{PADW{1'b0}}, imm};
        b_eff    = imm_sel ? imm_wide : reg_b;
    end
endmodule

// File: rtl/alu_addsub.sv
// Module alu_addsub
// Single adder for add and subtract (subtract by inverting B with carry in).
// Produces the two's-complement overflow indication of the signed operation.
module alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic         do_sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_in;

    // Add A to B or to its complement, then derive overflow from sign bits
    always_comb begin
        b_in = do_sub ? ~b : b;
        sum  = a + b_in + {{(W-1){1'b0}}, do_sub};
        ovf  = (a[W-1] == b_in[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_shifter.sv
// Module alu_shifter
// Logarithmic barrel shifter. Left shifts reuse the right-shift stages
// on a bit-reversed word. Only the low log2(W) bits of the amount are used.
// Assumes W is a power of two.
module alu_shifter #(
    parameter int unsigned W = 32
) (
    input  logic               go_left,
    input  logic               arith,
    input  logic [W-1:0]       a,
    input  logic [$clog2(W)-1:0] amt,
    output logic [W-1:0]       y
);
    localparam int unsigned SW = $clog2(W);

    logic [W-1:0] stg [SW+1];
    logic         fill;

    // Reverse bit order of a word
    function automatic logic [W-1:0] rev(logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    // Prepare stage input and the bit shifted in from the top
    always_comb begin
        stg[0] = go_left ? rev(a) : a;
        fill   = arith && !go_left && a[W-1];
    end

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int unsigned D = 1 << s;
        // One power-of-two right shift stage
        always_comb begin
            stg[s+1] = amt[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
        end
    end

    // Undo the reversal for left shifts
    always_comb begin
        y = go_left ? rev(stg[SW]) : stg[SW];
    end
endmodule

// File: rtl/alu_compare.sv
// Module alu_compare
// Evaluates one of six relations between A and B, signed or unsigned,
// from an equality and a less-than term.
module alu_compare #(
    parameter int unsigned W = 32
) (
    input  alu_pkg::alu_op_e op,
    input  logic             uns_sel,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic             hit
);
    logic eq;
    logic lt;

    // Form equal and less-than, then pick the relation
    always_comb begin
        eq = (a == b);
        lt = uns_sel ? (a < b) : ($signed(a) < $signed(b));
        unique case (op)
            alu_pkg::OP_SEQ: hit = eq;
            alu_pkg::OP_SNE: hit = !eq;
            alu_pkg::OP_SLT: hit = lt;
            alu_pkg::OP_SGT: hit = !lt && !eq;
            alu_pkg::OP_SLE: hit = lt || eq;
            alu_pkg::OP_SGE: hit = !lt;
            default:         hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/int_alu_setcond.sv
// Module int_alu_setcond
// Combinational integer ALU with set-on-condition results, load-high and
// shifts. Assumes XLEN = 2*IMM_W; holds no state and takes no clock.
module int_alu_setcond #(
    parameter int unsigned XLEN  = alu_pkg::XLEN,
    parameter int unsigned IMM_W = alu_pkg::IMM_W
) (
    input  logic [3:0]       op_code,
    input  logic             uns_sel,
    input  logic             imm_sel,
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    input  logic [IMM_W-1:0] imm_val,
    output logic [XLEN-1:0]  alu_result,
    output logic             alu_ovf
);
    import alu_pkg::*;

    localparam int unsigned SHW = $clog2(XLEN);
    localparam int unsigned LOW = XLEN - IMM_W;

    alu_op_e         op;
    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] sum;
    logic            sum_ovf;
    logic [XLEN-1:0] sh_y;
    logic            rel_hit;

    // Interpret the raw code as an operation
    always_comb op = alu_op_e'(op_code);

    alu_operand_sel #(.W(XLEN), .IW(IMM_W)) u_opsel (
        .op      (op),
        .uns_sel (uns_sel),
        .imm_sel (imm_sel),
        .reg_b   (opnd_b),
        .imm     (imm_val),
        .b_eff   (b_eff)
    );

    alu_addsub #(.W(XLEN)) u_addsub (
        .do_sub (op == OP_SUB),
        .a      (opnd_a),
        .b      (b_eff),
        .sum    (sum),
        .ovf    (sum_ovf)
    );

    alu_shifter #(.W(XLEN)) u_shift (
        .go_left (op == OP_SLL),
        .arith   (op == OP_SRA),
        .a       (opnd_a),
        .amt     (b_eff[SHW-1:0]),
        .y       (sh_y)
    );

    alu_compare #(.W(XLEN)) u_cmp (
        .op      (op),
        .uns_sel (uns_sel),
        .a       (opnd_a),
        .b       (b_eff),
        .hit     (rel_hit)
    );

    // Route the selected unit to the result and qualify overflow
    always_comb begin
        alu_ovf = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                alu_result = sum;
                alu_ovf    = sum_ovf && !uns_sel;
            end
            OP_AND:  alu_result = opnd_a & b_eff;
            OP_OR:   alu_result = opnd_a | b_eff;
            OP_XOR:  alu_result = opnd_a ^ b_eff;
            OP_SLL, OP_SRL, OP_SRA: alu_result = sh_y;
            OP_LHI:  alu_result = {imm_val, {LOW{1'b0}}};
            OP_SEQ, OP_SNE, OP_SLT, OP_SGT, OP_SLE, OP_SGE:
                     alu_result = {{(XLEN-1){1'b0}}, rel_hit};
            default: alu_result = '0;
        endcase
    end
endmodule

// File: rtl/alu_setcond_chk.sv
// Module alu_setcond_chk
// Port-level checks for int_alu_setcond, bound into every instance.
// The block is combinational, so the checks are immediate assertions.
module alu_setcond_chk #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IMM_W = 16
) (
    input logic [3:0]       op_code,
    input logic             uns_sel,
    input logic             imm_sel,
    input logic [XLEN-1:0]  opnd_a,
    input logic [XLEN-1:0]  opnd_b,
    input logic [IMM_W-1:0] imm_val,
    input logic [XLEN-1:0]  alu_result,
    input logic             alu_ovf
);
    localparam int unsigned LOW = XLEN - IMM_W;

    // Check the settled outputs against the operation class
    always_comb begin
        // R2: overflow only on signed add or subtract
        p_ovf_signed_only_r2: assert (!alu_ovf || (op_code <= 4'd1 && !uns_sel))
            else $error("overflow outside signed add/sub");
        // R3: register AND cannot set bits absent from either operand
        p_and_subset_r3: assert (!(op_code == 4'd2 && !imm_sel) ||
                                 ((alu_result & ~(opnd_a & opnd_b)) == '0))
            else $error("AND result has extra bits");
        // R5: load high places immediate on top and zeros below
        p_lhi_layout_r5: assert (op_code != 4'd8 ||
                                 alu_result == {imm_val, {LOW{1'b0}}})
            else $error("load-high layout wrong");
        // R6: set operations produce only 0 or 1
        p_set_boolean_r6: assert (!(op_code >= 4'd9 && op_code <= 4'd14) ||
                                  alu_result[XLEN-1:1] == '0)
            else $error("set result not boolean");
        // R8: unassigned code is inert
        p_nul_quiet_r8: assert (op_code != 4'd15 || (alu_result == '0 && !alu_ovf))
            else $error("unassigned code active");
    end
endmodule

bind int_alu_setcond alu_setcond_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
    .op_code    (op_code),
    .uns_sel    (uns_sel),
    .imm_sel    (imm_sel),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .imm_val    (imm_val),
    .alu_result (alu_result),
    .alu_ovf    (alu_ovf)
);

// File: tb/sim_int_alu_setcond.sv
// Bench sim_int_alu_setcond
// Sweeps every code and flag pair over a grid of operand corner values and
// compares against an arithmetic reference model.
module sim_int_alu_setcond;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic        uns_sel = 1'b0;
    logic        imm_sel = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] imm_val = '0;
    logic [31:0] alu_result;
    logic        alu_ovf;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // 250 MHz clock
    always #2 clk = ~clk;

    int_alu_setcond u0 (
        .op_code    (op_code),
        .uns_sel    (uns_sel),
        .imm_sel    (imm_sel),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .imm_val    (imm_val),
        .alu_result (alu_result),
        .alu_ovf    (alu_ovf)
    );

    // Corner operand values, including sign boundaries and amount 33
    function automatic logic [31:0] corner(int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h0000_0001;
            2: return 32'h0000_0002;  3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;  5: return 32'hFFFF_FFFF;
            6: return 32'h0000_FFFF;  7: return 32'h0000_8000;
            8: return 32'h1234_5678;  9: return 32'hFEDC_BA98;
            10: return 32'h0000_001F; default: return 32'h0000_0021;
        endcase
    endfunction

    // Requirement tag for an operation class
    function automatic string req_of(int op, bit u);
        if (op <= 1) return "R1";
        if (op <= 4) return "R3";
        if (op <= 7) return "R4";
        if (op == 8) return "R5";
        if (op <= 14) return u ? "R7" : "R6";
        return "R8";
    endfunction

    // Reference model: returns {overflow, result}
    function automatic logic [32:0] model(int op, bit u, bit is, logic [31:0] a,
                                          logic [31:0] b, logic [15:0] im);
        logic [31:0] bx;
        longint sa, sb, wide;
        bit sx;
        bit c;
        int amt;
        sx = ((op <= 1) || (op >= 9 && op <= 14)) && !u;
        bx = !is ? b : (sx ? {{16{im[15]}}, im} : {16'h0, im});
        sa = u ? longint'({32'h0, a}) : longint'($signed(a));
        sb = u ? longint'({32'h0, bx}) : longint'($signed(bx));
        amt = int'(bx % 32);
        c = 1'b0;
        case (op)
            0, 1: begin
                wide = (op == 0) ? sa + sb : sa - sb;
                return {(!u && (wide > 64'sd2147483647 || wide < -64'sd2147483648)),
                        wide[31:0]};
            end
            2: return {1'b0, a & bx};
            3: return {1'b0, a | bx};
            4: return {1'b0, a ^ bx};
            5: return {1'b0, a << amt};
            6: return {1'b0, a >> amt};
            7: return {1'b0, 32'($signed(a) >>> amt)};
            8: return {1'b0, im, 16'h0};
            9:  c = (sa == sb);
            10: c = (sa != sb);
            11: c = (sa <  sb);
            12: c = (sa >  sb);
            13: c = (sa <= sb);
            14: c = (sa >= sb);
            default: return 33'h0;
        endcase
        return {1'b0, 31'h0, c};
    endfunction

    // Compare one settled output pair with the expected pair
    task automatic check(string req, logic [32:0] exp);
        n_cmp++;
        if ({alu_ovf, alu_result} !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d u=%0b i=%0b a=%h b=%h imm=%h: got ovf=%0b res=%h, expected ovf=%0b res=%h",
                     req, op_code, uns_sel, imm_sel, opnd_a, opnd_b, imm_val,
                     alu_ovf, alu_result, exp[32], exp[31:0]);
        end
    endtask

    // Stimulus: reset-state check, then the full sweep
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 33'h0);  // all-zero inputs give a zero sum, no overflow
        for (int op = 0; op < 16; op++) begin
            for (int u = 0; u < 2; u++) begin
                for (int is = 0; is < 2; is++) begin
                    for (int ia = 0; ia < 12; ia++) begin
                        for (int ib = 0; ib < 12; ib++) begin
                            @(posedge clk);
                            op_code = 4'(op);
                            uns_sel = u[0];
                            imm_sel = is[0];
                            opnd_a  = corner(ia);
                            opnd_b  = corner(ib);
                            imm_val = corner(ib)[15:0];
                            @(negedge clk);
                            check(req_of(op, u[0]), model(op, u[0], is[0], opnd_a, opnd_b, imm_val));
                        end
                    end
                end
            end
        end
        // R2: explicit signed overflow corner, max + 1
        @(posedge clk);
        op_code = 4'd0; uns_sel = 1'b0; imm_sel = 1'b1;
        opnd_a = 32'h7FFF_FFFF; imm_val = 16'h0001;
        @(negedge clk);
        check("R2", {1'b1, 32'h8000_0000});
        // R2: same sum in unsigned form does not flag
        @(posedge clk);
        uns_sel = 1'b1;
        @(negedge clk);
        check("R2", {1'b0, 32'h8000_0000});
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule